// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block gives a host bus access to a byte-wide configuration register space through a pair of adjacent I/O addresses. The lower address is the index port: the host writes a register number there. The upper address is the data port: the host then reads or writes the selected register through it. A strap input picks one of two base addresses.

The register space is closed after reset. It opens only when a fixed key byte is written to the index port twice in a row. A separate key byte, also written to the index port, closes it again. One global register holds a logical-device number, and that number pages the upper part of the register space. Index values from the device window upward are passed out to a logical device's register file over a simple strobe interface, which also carries the current logical-device number. The global space also holds read-only identification bytes: a manufacturer ID, a device ID and a revision.

Host reads are combinational from the address. Host writes take effect at the rising clock edge where `bus_wr` is high. The host never drives `bus_wr` and `bus_rd` high in the same cycle.

Top module: `cfg_keyport`

## Requirements
- R1: With `strap_alt` low the index port is at 0x2E and the data port at 0x2F. With `strap_alt` high they are at 0x4E and 0x4F. A read of any other address returns 0xFF, and a write to any other address changes nothing.
- R2: After reset the block is locked (`cfg_open` low), the index is 0x00 and the logical-device number is 0x00.
- R3: Two consecutive index-port writes of 0x87 open the block. `cfg_open` goes high after the clock edge of the second write.
- R4: An index-port write of any value other than 0x87, placed between the two key writes, restarts the key sequence. Data-port writes do not take part in the sequence.
- R5: While locked, data-port writes are ignored, reads of either port return 0xFF, `dev_wr` and `dev_rd` stay low, and index-port writes do not change the index.
- R6: While open, an index-port write of 0xAA locks the block at the next edge and leaves the stored index unchanged.
- R7: While open, any other index-port write stores the value as the index, and a read of the index port returns it.
- R8: Index 0x07 is the logical-device select. Writing it through the data port sets `dev_ldn`, and reading it returns that value.
- R9: Identification reads: 0x20 returns the device ID high byte and 0x21 its low byte (defaults 0x0A and 0x51). 0x22 returns the revision (default 0x13). 0x23 returns 0x19 and 0x24 returns 0x34.
- R10: While open, with an index of 0x30 or above, a data-port write raises `dev_wr` for that cycle with `dev_addr` equal to the index and `dev_wdata` equal to the written byte. A data-port read raises `dev_rd` and returns `dev_rdata`.
- R11: Global indices below 0x30 that are not listed in R8 and R9 read as 0x00. Data writes to them change no state and raise no device strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| cfg_open | output | 1 | High while the configuration space is open |
| dev_ldn | output | 8 | Currently selected logical-device number |
| dev_addr | output | 8 | Register number passed to the logical device |
| dev_wdata | output | 8 | Write byte passed to the logical device |
| dev_wr | output | 1 | Write strobe to the logical device |
| dev_rd | output | 1 | Read strobe to the logical device |
| dev_rdata | input | 8 | Read byte returned by the logical device |

## Verification
Some properties are checked on every cycle. While locked, reads return 0xFF and no device strobe appears. Reads of unmapped addresses return 0xFF. Every opening is preceded by a key write, the close key always locks at the next edge, and a forwarded read returns the device byte. Other behaviours need whole sequences, so only the bench scenarios can show them: an unlock needs exactly two adjacent key writes, an interrupting write restarts the count, the index survives a close, the paged register holds its value, and the identification bytes sit at the right indices. The bench compares these against its own model, using directed cases and random traffic.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_ARMING = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_t;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
   parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              hit_idx,
   output logic              hit_dat
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (BASE_PRI[0] != 1'b0 || BASE_ALT[0] != 1'b0) begin : g_bad_base
         $error("cfg_port_decode: base addresses must be even");
      end
   endgenerate

   logic [ADDR_W-1:0] base;

   always_comb begin
      base    = strap_alt ? BASE_ALT : BASE_PRI;
      hit_idx = (bus_addr == base);
      hit_dat = (bus_addr == (base + ONE));
   end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
   import cfg_keyport_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] KEY_OPEN   = 8'h87,
   parameter logic [DATA_W-1:0] KEY_CLOSE  = 8'hAA,
   parameter int                KEY_REPEAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              open_o
);
   localparam int CNT_W = (KEY_REPEAT < 2) ? 1 : $clog2(KEY_REPEAT + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_REPEAT - 1);

   generate
      if (KEY_REPEAT < 1) begin : g_bad_rep
         $error("cfg_key_fsm: KEY_REPEAT must be at least 1");
      end
      if (KEY_OPEN == KEY_CLOSE) begin : g_bad_key
         $error("cfg_key_fsm: open and close keys must differ");
      end
   endgenerate

   key_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             is_key;

   assign is_key = (wdata == KEY_OPEN);

   generate
      if (KEY_REPEAT == 1) begin : g_single
         always_comb begin
            st_d  = st_q;
            cnt_d = '0;
            if (idx_wr) begin
               if (st_q != KS_OPEN && is_key)                  st_d = KS_OPEN;
               else if (st_q == KS_OPEN && wdata == KEY_CLOSE) st_d = KS_LOCKED;
            end
         end
      end else begin : g_multi
         always_comb begin
            st_d  = st_q;
            cnt_d = cnt_q;
            if (idx_wr) begin
               unique case (st_q)
                  KS_LOCKED: begin
                     if (is_key) begin
                        st_d  = KS_ARMING;
                        cnt_d = CNT_W'(1);
                     end
                  end
                  KS_ARMING: begin
                     if (!is_key) begin
                        st_d  = KS_LOCKED;
                        cnt_d = '0;
                     end else if (cnt_q == CNT_LAST) begin
                        st_d  = KS_OPEN;
                        cnt_d = '0;
                     end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                     end
                  end
                  KS_OPEN: begin
                     if (wdata == KEY_CLOSE) st_d = KS_LOCKED;
                  end
                  default: begin
                     st_d  = KS_LOCKED;
                     cnt_d = '0;
                  end
               endcase
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= KS_LOCKED;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign open_o = (st_q == KS_OPEN);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] KEY_CLOSE = 8'hAA,
   parameter logic [DATA_W-1:0] LDN_IDX   = 8'h07,
   parameter logic [DATA_W-1:0] DEVID_IDX = 8'h20,
   parameter logic [DATA_W-1:0] REV_IDX   = 8'h22,
   parameter logic [DATA_W-1:0] MFG_IDX   = 8'h23,
   parameter logic [DATA_W-1:0] DEV_BASE  = 8'h30,
   parameter logic [15:0]       MFG_ID    = 16'h1934,
   parameter logic [15:0]       DEV_ID    = 16'h0A51,
   parameter logic [7:0]        REV_ID    = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic              idx_wr,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] index_o,
   output logic [DATA_W-1:0] ldn_o,
   output logic              dev_sel_o,
   output logic [DATA_W-1:0] glob_rdata
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("cfg_global_regs: identification bytes need DATA_W of 8");
      end
      if (DEV_BASE <= MFG_IDX + ONE || DEV_BASE <= LDN_IDX) begin : g_bad_map
         $error("cfg_global_regs: device window overlaps global registers");
      end
   endgenerate

   logic [DATA_W-1:0] index_q, ldn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         ldn_q   <= '0;
      end else begin
         if (open_i && idx_wr && wdata != KEY_CLOSE) index_q <= wdata;
         if (open_i && dat_wr && index_q == LDN_IDX) ldn_q   <= wdata;
      end
   end

   always_comb begin
      glob_rdata = '0;
      if      (index_q == LDN_IDX)         glob_rdata = ldn_q;
      else if (index_q == DEVID_IDX)       glob_rdata = DEV_ID[15:8];
      else if (index_q == DEVID_IDX + ONE) glob_rdata = DEV_ID[7:0];
      else if (index_q == REV_IDX)         glob_rdata = REV_ID;
      else if (index_q == MFG_IDX)         glob_rdata = MFG_ID[15:8];
      else if (index_q == MFG_IDX + ONE)   glob_rdata = MFG_ID[7:0];
   end

   assign index_o   = index_q;
   assign ldn_o     = ldn_q;
   assign dev_sel_o = (index_q >= DEV_BASE);
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport #(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter logic [15:0] BASE_PRI   = 16'h002E,
   parameter logic [15:0] BASE_ALT   = 16'h004E,
   parameter logic [7:0]  KEY_OPEN   = 8'h87,
   parameter logic [7:0]  KEY_CLOSE  = 8'hAA,
   parameter int          KEY_REPEAT = 2,
   parameter logic [7:0]  DEV_BASE   = 8'h30,
   parameter logic [15:0] MFG_ID     = 16'h1934,
   parameter logic [15:0] DEV_ID     = 16'h0A51,
   parameter logic [7:0]  REV_ID     = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cfg_open,
   output logic [DATA_W-1:0] dev_ldn,
   output logic [DATA_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              dev_wr,
   output logic              dev_rd,
   input  logic [DATA_W-1:0] dev_rdata
);
   localparam logic [DATA_W-1:0] FLOAT = '1;

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
         $error("cfg_keyport: ADDR_W must be 8 to 16");
      end
   endgenerate

   logic              hit_idx, hit_dat, idx_wr, dat_wr, open_s, dev_sel;
   logic [DATA_W-1:0] index_s, glob_rdata;

   cfg_port_decode #(
      .ADDR_W  (ADDR_W),
      .BASE_PRI(BASE_PRI[ADDR_W-1:0]),
      .BASE_ALT(BASE_ALT[ADDR_W-1:0])
   ) u_dec (
      .strap_alt(strap_alt),
      .bus_addr (bus_addr),
      .hit_idx  (hit_idx),
      .hit_dat  (hit_dat)
   );

   assign idx_wr = bus_wr & hit_idx;
   assign dat_wr = bus_wr & hit_dat;

   cfg_key_fsm #(
      .DATA_W    (DATA_W),
      .KEY_OPEN  (KEY_OPEN[DATA_W-1:0]),
      .KEY_CLOSE (KEY_CLOSE[DATA_W-1:0]),
      .KEY_REPEAT(KEY_REPEAT)
   ) u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_wr(idx_wr),
      .wdata (bus_wdata),
      .open_o(open_s)
   );

   cfg_global_regs #(
      .DATA_W   (DATA_W),
      .KEY_CLOSE(KEY_CLOSE[DATA_W-1:0]),
      .DEV_BASE (DEV_BASE[DATA_W-1:0]),
      .MFG_ID   (MFG_ID),
      .DEV_ID   (DEV_ID),
      .REV_ID   (REV_ID)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_i    (open_s),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .wdata     (bus_wdata),
      .index_o   (index_s),
      .ldn_o     (dev_ldn),
      .dev_sel_o (dev_sel),
      .glob_rdata(glob_rdata)
   );

   assign cfg_open  = open_s;
   assign dev_addr  = index_s;
   assign dev_wdata = bus_wdata;
   assign dev_wr    = open_s & dat_wr & dev_sel;
   assign dev_rd    = open_s & bus_rd & hit_dat & dev_sel;

   always_comb begin
      if (!open_s || !(hit_idx || hit_dat)) bus_rdata = FLOAT;
      else if (hit_idx)                     bus_rdata = index_s;
      else if (dev_sel)                     bus_rdata = dev_rdata;
      else                                  bus_rdata = glob_rdata;
   end
endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] BASE_PRI  = 16'h002E,
   parameter logic [15:0] BASE_ALT  = 16'h004E,
   parameter logic [7:0]  KEY_OPEN  = 8'h87,
   parameter logic [7:0]  KEY_CLOSE = 8'hAA
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_alt,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              cfg_open,
   input logic              dev_wr,
   input logic              dev_rd,
   input logic [DATA_W-1:0] dev_rdata
);
   logic [ADDR_W-1:0] base;
   logic              at_idx, at_dat, idx_wr;

   assign base   = strap_alt ? BASE_ALT[ADDR_W-1:0] : BASE_PRI[ADDR_W-1:0];
   assign at_idx = (bus_addr == base);
   assign at_dat = (bus_addr == base + ADDR_W'(1));
   assign idx_wr = bus_wr && at_idx;

   AST_MISS_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !at_idx && !at_dat) |-> bus_rdata == '1);                  // R1
   AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(idx_wr && bus_wdata == KEY_OPEN[DATA_W-1:0])); // R3
   AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && bus_rd) |-> bus_rdata == '1);                           // R5
   AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> (!dev_wr && !dev_rd));                                  // R5
   AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && idx_wr && bus_wdata == KEY_CLOSE[DATA_W-1:0]) |=> !cfg_open); // R6
   AST_DEV_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rd |-> (bus_rdata == dev_rdata && at_dat));                       // R10
endmodule

bind cfg_keyport cfg_keyport_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .BASE_PRI (BASE_PRI),
   .BASE_ALT (BASE_ALT),
   .KEY_OPEN (KEY_OPEN),
   .KEY_CLOSE(KEY_CLOSE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strap_alt(strap_alt),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .cfg_open (cfg_open),
   .dev_wr   (dev_wr),
   .dev_rd   (dev_rd),
   .dev_rdata(dev_rdata)
);

// File: tb/tb_cfg_keyport.sv
module tb_cfg_keyport;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic [15:0] bus_addr = 16'h0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = 8'h0;
   logic [7:0]  bus_rdata;
   logic        cfg_open;
   logic [7:0]  dev_ldn, dev_addr, dev_wdata, dev_rdata;
   logic        dev_wr, dev_rd;

   int n_chk = 0;
   int n_fail = 0;

   // model state, written from the requirements
   bit       m_open = 0;
   int       m_arm = 0;
   bit [7:0] m_idx = 0;
   bit [7:0] m_ldn = 0;
   int       m_devwr = 0;
   int       devwr_seen = 0;
   bit [7:0] last_da, last_dd, last_dl;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_keyport dut (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cfg_open(cfg_open), .dev_ldn(dev_ldn),
      .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_wr(dev_wr),
      .dev_rd(dev_rd), .dev_rdata(dev_rdata)
   );

   function automatic bit [7:0] dev_resp(bit [7:0] a, bit [7:0] l);
      return a ^ {l[3:0], l[3:0]} ^ 8'h5A;
   endfunction

   assign dev_rdata = dev_resp(dev_addr, dev_ldn);

   always @(posedge clk) begin
      if (rst_n && dev_wr) begin
         devwr_seen <= devwr_seen + 1;
         last_da    <= dev_addr;
         last_dd    <= dev_wdata;
         last_dl    <= dev_ldn;
      end
   end

   function automatic bit [15:0] base_of();
      return strap_alt ? 16'h004E : 16'h002E;
   endfunction

   function automatic bit [7:0] exp_read(bit [15:0] a);
      if (!m_open) return 8'hFF;
      if (a == base_of()) return m_idx;
      if (a != base_of() + 16'd1) return 8'hFF;
      if (m_idx >= 8'h30) return dev_resp(m_idx, m_ldn);
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return 8'h0A;
         8'h21: return 8'h51;
         8'h22: return 8'h13;
         8'h23: return 8'h19;
         8'h24: return 8'h34;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(bit [15:0] a, bit [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a == base_of()) begin
         if (!m_open) begin
            if (d == 8'h87) begin
               m_arm++;
               if (m_arm == 2) begin m_open = 1; m_arm = 0; end
            end else m_arm = 0;
         end else if (d == 8'hAA) m_open = 0;
         else m_idx = d;
      end else if (a == base_of() + 16'd1 && m_open) begin
         if (m_idx == 8'h07) m_ldn = d;
         if (m_idx >= 8'h30) m_devwr++;
      end
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd_chk(bit [15:0] a, string req);
      bit [7:0] e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      e = exp_read(a);
      #1 chk(bus_rdata == e, req, bus_rdata, e);
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic unlock();
      wr(base_of(), 8'h87);
      wr(base_of(), 8'h87);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1 chk(cfg_open == 1'b0, "R2", cfg_open, 0);
      rd_chk(16'h002E, "R5");
      rd_chk(16'h002F, "R5");
      // R5 locked data write ignored
      wr(16'h002F, 8'h55);
      wr(16'h002E, 8'h40);
      chk(devwr_seen == 0, "R5", devwr_seen, 0);
      // R4 interrupted key sequence
      wr(16'h002E, 8'h87);
      wr(16'h002F, 8'h12);
      wr(16'h002E, 8'h11);
      wr(16'h002E, 8'h87);
      #1 chk(cfg_open == 1'b0, "R4", cfg_open, 0);
      wr(16'h002E, 8'h87);
      #1 chk(cfg_open == 1'b1, "R3", cfg_open, 1);
      rd_chk(16'h002E, "R2");
      rd_chk(16'h002F, "R11");
      wr(16'h002E, 8'h07);
      rd_chk(16'h002F, "R2");
      // R9 identification bytes
      for (int i = 8'h20; i <= 8'h24; i++) begin
         wr(16'h002E, 8'(i));
         rd_chk(16'h002F, "R9");
      end
      // R8 logical device select
      wr(16'h002E, 8'h07);
      wr(16'h002F, 8'h06);
      rd_chk(16'h002F, "R8");
      #1 chk(dev_ldn == 8'h06, "R8", dev_ldn, 6);
      // R10 forwarding
      wr(16'h002E, 8'h45);
      rd_chk(16'h002E, "R7");
      wr(16'h002F, 8'hC3);
      #1 chk(devwr_seen == 1 && last_da == 8'h45 && last_dd == 8'hC3 && last_dl == 8'h06,
             "R10", {last_da, last_dd}, 16'h45C3);
      rd_chk(16'h002F, "R10");
      wr(16'h002E, 8'h30);
      rd_chk(16'h002F, "R10");
      // R11 unlisted global
      wr(16'h002E, 8'h10);
      wr(16'h002F, 8'h99);
      rd_chk(16'h002F, "R11");
      wr(16'h002E, 8'h2F);
      wr(16'h002F, 8'h77);
      rd_chk(16'h002F, "R11");
      #1 chk(devwr_seen == 1 && dev_ldn == 8'h06, "R11", devwr_seen, 1);
      // R1 other addresses
      rd_chk(16'h004E, "R1");
      rd_chk(16'h012E, "R1");
      wr(16'h004E, 8'hAA);
      wr(16'h004F, 8'h01);
      #1 chk(cfg_open == 1'b1, "R1", cfg_open, 1);
      rd_chk(16'h002E, "R1");
      // R6 close keeps index
      wr(16'h002E, 8'h22);
      wr(16'h002E, 8'hAA);
      #1 chk(cfg_open == 1'b0, "R6", cfg_open, 0);
      rd_chk(16'h002F, "R6");
      unlock();
      rd_chk(16'h002E, "R6");
      // R1 alternate base
      wr(16'h002E, 8'hAA);
      @(negedge clk) strap_alt = 1'b1;
      rd_chk(16'h002E, "R1");
      unlock();
      #1 chk(cfg_open == 1'b1, "R1", cfg_open, 1);
      rd_chk(16'h004E, "R1");
      rd_chk(16'h002F, "R1");
      // random traffic
      for (int n = 0; n < 400; n++) begin
         bit [15:0] a;
         bit [7:0]  d;
         int        pick;
         a = base_of() + 16'($urandom_range(0, 1));
         pick = $urandom_range(0, 9);
         case (pick)
            0, 1:    d = 8'h87;
            2:       d = 8'hAA;
            3:       d = 8'h07;
            4:       d = 8'(8'h20 + $urandom_range(0, 4));
            5:       d = 8'(8'h30 + $urandom_range(0, 15));
            default: d = 8'($urandom_range(0, 255));
         endcase
         if ($urandom_range(0, 2) == 0) rd_chk(a, "R10");
         else wr(a, d);
      end
      #1 chk(devwr_seen == m_devwr, "R10", devwr_seen, m_devwr);
      chk(cfg_open == m_open, "R3", cfg_open, m_open);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule